// File: doc/BRIEF.md
# Latency-Table Issue Scoreboard

This block is the issue controller of a single in-order thread unit. Decoded instructions arrive one at a time on a valid/ready port. Each carries an operation class, a count of source operands, up to three source register numbers, an optional destination register and, for memory operations, a target address. The controller holds the instruction in a single front slot while its registers are read. It stalls the instruction while any register it touches still waits for an earlier result. It then emits an issue strobe with a sequence tag.

Every class has two fixed latencies. The occupancy count says how many cycles the issue slot stays taken. The result delay says how much longer the destination waits before it is written. For memory operations the delay depends on which address window the target falls in. A table with one entry per register holds a busy flag, a countdown and the tag for each result in flight. Results therefore finish out of order. Finished results leave on a completion strobe, one per cycle, lowest tag first. Any number of results may finish together, because write ports are not modelled.

Top module: `sb_issue_ctrl`

## Requirements
- R1: Class codes and their (occupancy x, delay d) pairs are: 0 branch (2,0), 1 population count (1,1), 2 integer multiply (1,5), 3 integer divide/remainder (1,33), 4 float add/multiply/convert (1,5), 5 fused multiply-add (1,10), 6 float divide (1,33), 7 float square root (1,56). Codes 9 to 15 are (1,0).
- R2: Class code 8 is a memory operation with x=1. Its delay is 36 when the address is at or above 0x80000000, 2 when the address lies in 0x40000000..0x7FFFFFFF, and 20 below 0x40000000.
- R3: An instruction is accepted when in_valid and in_ready are both high at a rising edge. It reads registers for 1 cycle, or for 2 cycles when in_nsrc is 3, before it can issue. in_ready is high whenever the front slot is empty or its instruction issues in the current cycle.
- R4: Instructions issue strictly in acceptance order. iss_tag starts at 0 after reset, rises by one per issue (modulo 2^TAG_W), and iss_dst shows the issued destination.
- R5: An instruction does not issue, and does not advance its read cycles, while one of its first in_nsrc sources is busy. It is also held while its destination is busy and in_dst_en is set.
- R6: After an issue in cycle C, the next issue happens no earlier than cycle C+x.
- R7: A result issued in cycle C with in_dst_en set is reported on the completion port no earlier than cycle C+x+d. It is reported exactly then when no other finished result has a lower tag. Its register stays busy up to and including its report cycle.
- R8: When several results are finished, exactly one is reported per cycle: the one with the lowest tag. The others wait in later cycles.
- R9: A synchronous active-high reset clears the front slot, the busy table, the occupancy count and the tag counter. In the cycle after reset, in_ready is 1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Front slot can take the offered instruction |
| in_class | input | 4 | Operation class code |
| in_nsrc | input | 2 | Number of source operands, 0..3 |
| in_src0 | input | REG_W | First source register |
| in_src1 | input | REG_W | Second source register |
| in_src2 | input | REG_W | Third source register |
| in_dst | input | REG_W | Destination register |
| in_dst_en | input | 1 | Instruction writes a destination |
| in_addr | input | ADDR_W | Target address for memory operations |
| iss_valid | output | 1 | Issue strobe |
| iss_tag | output | TAG_W | Sequence tag of the issued instruction |
| iss_dst | output | REG_W | Destination of the issued instruction |
| cmp_valid | output | 1 | Completion (writeback) strobe |
| cmp_dst | output | REG_W | Register being written back |
| cmp_tag | output | TAG_W | Tag of the completing instruction |

## Verification
The hardest case to reach from the ports is two or more results finishing in the same cycle. Their issue times must differ by exactly the difference of their latencies, and a stall or a branch gap breaks that alignment. The stimulus draws class, operand count and address at random, and it uses a register pool of only eight entries. Delays from 1 to 57 then overlap often, so same-cycle finishes, read-after-write stalls and write-after-write stalls all occur many times. A directed opening covers each address window edge, a three-operand read and a branch gap.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int OCC_W   = 2;
   localparam int LAT_MAX = 57;

   typedef logic [3:0] op_class_t;

   localparam op_class_t OPC_BRANCH = 4'd0;
   localparam op_class_t OPC_POPC   = 4'd1;
   localparam op_class_t OPC_IMUL   = 4'd2;
   localparam op_class_t OPC_IDIV   = 4'd3;
   localparam op_class_t OPC_FARITH = 4'd4;
   localparam op_class_t OPC_FMA    = 4'd5;
   localparam op_class_t OPC_FDIV   = 4'd6;
   localparam op_class_t OPC_FSQRT  = 4'd7;
   localparam op_class_t OPC_MEM    = 4'd8;

   localparam int DLY_SPM  = 2;
   localparam int DLY_GLB  = 20;
   localparam int DLY_DRAM = 36;
endpackage

// File: rtl/sb_lat_lookup.sv
module sb_lat_lookup
   import sb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 6,
   parameter logic [ADDR_W-1:0] SPM_BASE  = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] DRAM_BASE = 32'h8000_0000
) (
   input  op_class_t         cls,
   input  logic [ADDR_W-1:0] addr,
   output logic [OCC_W-1:0]  occ,
   output logic [CNT_W-1:0]  dly
);
   logic [CNT_W-1:0] mem_dly;

   always_comb begin
      if (addr >= DRAM_BASE)     mem_dly = CNT_W'(DLY_DRAM);
      else if (addr >= SPM_BASE) mem_dly = CNT_W'(DLY_SPM);
      else                       mem_dly = CNT_W'(DLY_GLB);
   end

   always_comb begin
      occ = OCC_W'(1);
      unique case (cls)
         OPC_BRANCH: begin occ = OCC_W'(2); dly = '0; end
         OPC_POPC:   dly = CNT_W'(1);
         OPC_IMUL:   dly = CNT_W'(5);
         OPC_IDIV:   dly = CNT_W'(33);
         OPC_FARITH: dly = CNT_W'(5);
         OPC_FMA:    dly = CNT_W'(10);
         OPC_FDIV:   dly = CNT_W'(33);
         OPC_FSQRT:  dly = CNT_W'(56);
         OPC_MEM:    dly = mem_dly;
         default:    dly = '0;
      endcase
   end
endmodule

// File: rtl/sb_pend_table.sv
module sb_pend_table #(
   parameter int NREG  = 16,
   parameter int TAG_W = 8,
   parameter int CNT_W = 6,
   parameter int REG_W = $clog2(NREG)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        set_en,
   input  logic [REG_W-1:0]            set_idx,
   input  logic [CNT_W-1:0]            set_cnt,
   input  logic [TAG_W-1:0]            set_tag,
   input  logic                        clr_en,
   input  logic [REG_W-1:0]            clr_idx,
   output logic [NREG-1:0]             busy,
   output logic [NREG-1:0]             done,
   output logic [NREG-1:0][TAG_W-1:0]  tags
);
   for (genvar r = 0; r < NREG; r++) begin : g_ent
      logic             pend_q;
      logic [CNT_W-1:0] cnt_q;
      logic [TAG_W-1:0] tag_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            tag_q  <= '0;
         end else if (set_en && set_idx == REG_W'(r)) begin
            pend_q <= 1'b1;
            cnt_q  <= set_cnt;
            tag_q  <= set_tag;
         end else begin
            if (clr_en && clr_idx == REG_W'(r)) pend_q <= 1'b0;
            if (pend_q && cnt_q != '0)          cnt_q  <= cnt_q - CNT_W'(1);
         end
      end

      assign busy[r] = pend_q;
      assign done[r] = pend_q && cnt_q == '0;
      assign tags[r] = tag_q;
   end
endmodule

// File: rtl/sb_cmp_pick.sv
module sb_cmp_pick #(
   parameter int NREG  = 16,
   parameter int TAG_W = 8,
   parameter int REG_W = $clog2(NREG)
) (
   input  logic [NREG-1:0]             done,
   input  logic [NREG-1:0][TAG_W-1:0]  tags,
   output logic                        found,
   output logic [REG_W-1:0]            idx,
   output logic [TAG_W-1:0]            tag
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      tag   = '0;
      for (int r = 0; r < NREG; r++) begin
         if (done[r] && (!found || tags[r] < tag)) begin
            found = 1'b1;
            idx   = REG_W'(r);
            tag   = tags[r];
         end
      end
   end
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
   import sb_pkg::*;
#(
   parameter int NREG   = 16,
   parameter int TAG_W  = 8,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 6,
   parameter logic [ADDR_W-1:0] SPM_BASE  = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] DRAM_BASE = 32'h8000_0000,
   parameter int REG_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [3:0]        in_class,
   input  logic [1:0]        in_nsrc,
   input  logic [REG_W-1:0]  in_src0,
   input  logic [REG_W-1:0]  in_src1,
   input  logic [REG_W-1:0]  in_src2,
   input  logic [REG_W-1:0]  in_dst,
   input  logic              in_dst_en,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              iss_valid,
   output logic [TAG_W-1:0]  iss_tag,
   output logic [REG_W-1:0]  iss_dst,
   output logic              cmp_valid,
   output logic [REG_W-1:0]  cmp_dst,
   output logic [TAG_W-1:0]  cmp_tag
);
   localparam int NSRC = 3;

   if (NREG < 2 || (1 << REG_W) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if ((1 << CNT_W) <= LAT_MAX) begin : g_bad_cnt
      $error("CNT_W too narrow for the longest latency");
   end
   if ((1 << TAG_W) <= LAT_MAX) begin : g_bad_tag
      $error("TAG_W too narrow to keep tags in flight unique");
   end
   if (DRAM_BASE <= SPM_BASE) begin : g_bad_map
      $error("DRAM_BASE must lie above SPM_BASE");
   end

   // front slot
   logic                       h_v;
   logic [1:0]                 h_nsrc;
   logic [NSRC-1:0][REG_W-1:0] h_src;
   logic [REG_W-1:0]           h_dst;
   logic                       h_dst_en;
   logic [OCC_W-1:0]           h_x;
   logic [CNT_W-1:0]           h_d;
   logic [1:0]                 h_rd;
   logic [OCC_W-1:0]           occ_q;
   logic [TAG_W-1:0]           tag_q;

   logic [OCC_W-1:0]           lk_x;
   logic [CNT_W-1:0]           lk_d;
   logic [NREG-1:0]            busy_vec;
   logic [NREG-1:0]            done_vec;
   logic [NREG-1:0][TAG_W-1:0] tag_vec;
   logic                       hazard;
   logic                       issue_go;
   logic                       accept;

   sb_lat_lookup #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SPM_BASE(SPM_BASE), .DRAM_BASE(DRAM_BASE)
   ) u_lat (
      .cls(in_class), .addr(in_addr), .occ(lk_x), .dly(lk_d)
   );

   always_comb begin
      hazard = h_dst_en && busy_vec[h_dst];
      for (int s = 0; s < NSRC; s++) begin
         if (s < int'(h_nsrc) && busy_vec[h_src[s]]) hazard = 1'b1;
      end
   end

   assign issue_go = h_v && !hazard && h_rd == 2'd1 && occ_q == '0;
   assign in_ready = !h_v || issue_go;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         h_v      <= 1'b0;
         h_nsrc   <= '0;
         h_src    <= '0;
         h_dst    <= '0;
         h_dst_en <= 1'b0;
         h_x      <= '0;
         h_d      <= '0;
         h_rd     <= '0;
      end else if (accept) begin
         h_v      <= 1'b1;
         h_nsrc   <= in_nsrc;
         h_src    <= {in_src2, in_src1, in_src0};
         h_dst    <= in_dst;
         h_dst_en <= in_dst_en;
         h_x      <= lk_x;
         h_d      <= lk_d;
         h_rd     <= (in_nsrc == 2'd3) ? 2'd2 : 2'd1;
      end else if (issue_go) begin
         h_v <= 1'b0;
      end else if (h_v && !hazard && h_rd > 2'd1) begin
         h_rd <= h_rd - 2'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         occ_q <= '0;
         tag_q <= '0;
      end else if (issue_go) begin
         occ_q <= h_x - OCC_W'(1);
         tag_q <= tag_q + TAG_W'(1);
      end else if (occ_q != '0) begin
         occ_q <= occ_q - OCC_W'(1);
      end
   end

   sb_pend_table #(
      .NREG(NREG), .TAG_W(TAG_W), .CNT_W(CNT_W), .REG_W(REG_W)
   ) u_tab (
      .clk(clk), .rst(rst),
      .set_en(issue_go && h_dst_en), .set_idx(h_dst),
      .set_cnt(CNT_W'(h_x) + h_d - CNT_W'(1)), .set_tag(tag_q),
      .clr_en(cmp_valid), .clr_idx(cmp_dst),
      .busy(busy_vec), .done(done_vec), .tags(tag_vec)
   );

   sb_cmp_pick #(
      .NREG(NREG), .TAG_W(TAG_W), .REG_W(REG_W)
   ) u_pick (
      .done(done_vec), .tags(tag_vec),
      .found(cmp_valid), .idx(cmp_dst), .tag(cmp_tag)
   );

   assign iss_valid = issue_go;
   assign iss_tag   = tag_q;
   assign iss_dst   = h_dst;
endmodule

// File: rtl/sb_issue_ctrl_chk.sv
module sb_issue_ctrl_chk #(
   parameter int NREG  = 16,
   parameter int REG_W = $clog2(NREG),
   parameter int OCC_W = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             iss_valid,
   input logic [REG_W-1:0] iss_dst,
   input logic             cmp_valid,
   input logic [REG_W-1:0] cmp_dst,
   input logic [NREG-1:0]  busy,
   input logic             h_dst_en,
   input logic [OCC_W-1:0] h_x
);
   AST_ISSUE_DST_FREE: assert property (@(posedge clk) disable iff (rst)
      iss_valid && h_dst_en |-> !busy[iss_dst]); // R5

   AST_BRANCH_GAP: assert property (@(posedge clk) disable iff (rst)
      iss_valid && h_x == OCC_W'(2) |=> !iss_valid); // R6

   AST_CMP_FREES_REG: assert property (@(posedge clk) disable iff (rst)
      cmp_valid |=> !busy[$past(cmp_dst)]); // R7

   AST_CMP_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
      cmp_valid |-> busy[cmp_dst]); // R8

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> !iss_valid && !cmp_valid); // R9
endmodule

bind sb_issue_ctrl sb_issue_ctrl_chk #(.NREG(NREG), .REG_W(REG_W)) u_chk (
   .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_dst(iss_dst),
   .cmp_valid(cmp_valid), .cmp_dst(cmp_dst), .busy(busy_vec),
   .h_dst_en(h_dst_en), .h_x(h_x)
);

// File: tb/sb_issue_ctrl_test.sv
module sb_issue_ctrl_test;
   localparam int NREG = 16;
   localparam int RW   = 4;
   localparam int TW   = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0, in_ready, in_dst_en = 1'b0;
   logic [3:0] in_class = '0;
   logic [1:0] in_nsrc = '0;
   logic [RW-1:0] in_src0 = '0, in_src1 = '0, in_src2 = '0, in_dst = '0;
   logic [31:0] in_addr = '0;
   logic iss_valid, cmp_valid;
   logic [TW-1:0] iss_tag, cmp_tag;
   logic [RW-1:0] iss_dst, cmp_dst;

   always #4 clk = ~clk;

   sb_issue_ctrl uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_class(in_class), .in_nsrc(in_nsrc), .in_src0(in_src0),
      .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst),
      .in_dst_en(in_dst_en), .in_addr(in_addr), .iss_valid(iss_valid),
      .iss_tag(iss_tag), .iss_dst(iss_dst), .cmp_valid(cmp_valid),
      .cmp_dst(cmp_dst), .cmp_tag(cmp_tag)
   );

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   // reference state
   bit m_hv, m_dst_en;
   int m_nsrc, m_src[3], m_dst, m_x, m_d, m_rd, m_occ, m_tag;
   bit m_pend[NREG];
   int m_cnt[NREG], m_mtag[NREG];
   // expectations for the current cycle
   bit e_iss, e_rdy, e_cmp;
   int e_cidx;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int lat_x(int c);
      return (c == 0) ? 2 : 1;
   endfunction

   function automatic int lat_d(int c, logic [31:0] a);
      case (c)
         0: return 0;   1: return 1;   2: return 5;   3: return 33;
         4: return 5;   5: return 10;  6: return 33;  7: return 56;
         8: begin
            if (a[31]) return 36;
            if (a[30]) return 2;
            return 20;
         end
         default: return 0;
      endcase
   endfunction

   task automatic model_reset();
      m_hv = 0; m_rd = 0; m_occ = 0; m_tag = 0; m_dst_en = 0;
      for (int r = 0; r < NREG; r++) begin
         m_pend[r] = 0; m_cnt[r] = 0; m_mtag[r] = 0;
      end
   endtask

   task automatic model_expect(bit haz_only_dummy);
      bit haz;
      int best;
      haz = m_dst_en && m_pend[m_dst];
      for (int s = 0; s < 3; s++) if (s < m_nsrc && m_pend[m_src[s]]) haz = 1;
      e_iss = m_hv && !haz && m_rd == 1 && m_occ == 0;
      e_rdy = !m_hv || e_iss;
      e_cmp = 0; e_cidx = 0; best = 0;
      for (int r = 0; r < NREG; r++) begin
         if (m_pend[r] && m_cnt[r] == 0 && (!e_cmp || m_mtag[r] < best)) begin
            e_cmp = 1; e_cidx = r; best = m_mtag[r];
         end
      end
      if (haz_only_dummy) m_rd = m_rd;
   endtask

   task automatic model_step(bit acc);
      bit haz;
      haz = m_dst_en && m_pend[m_dst];
      for (int s = 0; s < 3; s++) if (s < m_nsrc && m_pend[m_src[s]]) haz = 1;
      if (e_cmp) m_pend[e_cidx] = 0;
      for (int r = 0; r < NREG; r++) if (m_pend[r] && m_cnt[r] > 0) m_cnt[r]--;
      if (e_iss) begin
         if (m_dst_en) begin
            m_pend[m_dst] = 1; m_cnt[m_dst] = m_x + m_d - 1; m_mtag[m_dst] = m_tag;
         end
         m_tag = (m_tag + 1) % 256;
         m_occ = m_x - 1;
      end else if (m_occ > 0) m_occ--;
      if (acc) begin
         m_hv = 1; m_nsrc = int'(in_nsrc);
         m_src[0] = int'(in_src0); m_src[1] = int'(in_src1); m_src[2] = int'(in_src2);
         m_dst = int'(in_dst); m_dst_en = in_dst_en;
         m_x = lat_x(int'(in_class)); m_d = lat_d(int'(in_class), in_addr);
         m_rd = (in_nsrc == 2'd3) ? 2 : 1;
      end else if (e_iss) m_hv = 0;
      else if (m_hv && !haz && m_rd > 1) m_rd--;
   endtask

   task automatic put(int c, int ns, int s0, int s1, int s2, int d, bit de, logic [31:0] a);
      in_class = 4'(c); in_nsrc = 2'(ns);
      in_src0 = RW'(s0); in_src1 = RW'(s1); in_src2 = RW'(s2);
      in_dst = RW'(d); in_dst_en = de; in_addr = a;
   endtask

   task automatic gen(int k);
      logic [31:0] a;
      case (k)
         0: put(7, 0, 0, 0, 0, 1, 1, 0);             // long delay
         1: put(15, 1, 1, 0, 0, 2, 1, 0);            // waits on r1 (R5)
         2: put(5, 3, 3, 4, 5, 6, 1, 0);             // two read cycles (R3)
         3: put(0, 0, 0, 0, 0, 0, 0, 0);             // branch gap (R6)
         4: put(8, 0, 0, 0, 0, 9, 1, 32'h8000_0000); // R2 window edges
         5: put(8, 0, 0, 0, 0, 10, 1, 32'h7FFF_FFFF);
         6: put(8, 0, 0, 0, 0, 11, 1, 32'h3FFF_FFFF);
         7: put(8, 0, 0, 0, 0, 12, 1, 32'h4000_0000);
         8: put(4, 0, 0, 0, 0, 13, 1, 0);
         9: put(15, 0, 0, 0, 0, 14, 1, 0);
         default: begin
            case ($urandom_range(0, 3))
               0: a = 32'h8000_0000 | 32'($urandom_range(0, 4095));
               1: a = 32'h4000_0000 | 32'($urandom_range(0, 4095));
               2: a = 32'($urandom_range(0, 4095));
               default: a = $urandom;
            endcase
            put($urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 7),
                $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                $urandom_range(0, 3) != 0, a);
         end
      endcase
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      int k;
      bit cur_v, acc, post_rst;
      void'($urandom(32'd20250604));
      model_reset();
      k = 0; cur_v = 0; post_rst = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check(in_ready && !iss_valid && !cmp_valid, "R9", "reset state",
            {in_ready, iss_valid, cmp_valid}, 3'b100);
      for (int cyc = 0; cyc < 12000; cyc++) begin
         if (cyc != 0) @(negedge clk);
         rst = (cyc == 6000 || cyc == 6001);
         if (rst) begin
            cur_v = 0; in_valid = 0;
            @(posedge clk);
            model_reset();
            post_rst = 1;
            continue;
         end
         if (!cur_v && (k < 10 || $urandom_range(0, 3) != 0)) begin
            gen(k); k++; cur_v = 1;
         end
         in_valid = cur_v;
         #1;
         model_expect(1'b0);
         if (post_rst) begin
            check(in_ready && !iss_valid && !cmp_valid, "R9", "after reset",
                  {in_ready, iss_valid, cmp_valid}, 3'b100);
            post_rst = 0;
         end
         check(in_ready == e_rdy, "R3", "in_ready", in_ready, e_rdy);
         check(iss_valid == e_iss, "R3 R5 R6", "iss_valid", iss_valid, e_iss);
         if (e_iss && iss_valid) begin
            check(int'(iss_tag) == m_tag, "R4", "iss_tag", iss_tag, m_tag);
            check(int'(iss_dst) == m_dst, "R4", "iss_dst", iss_dst, m_dst);
         end
         check(cmp_valid == e_cmp, "R1 R2 R7", "cmp_valid", cmp_valid, e_cmp);
         if (e_cmp && cmp_valid) begin
            check(int'(cmp_dst) == e_cidx, "R8", "cmp_dst", cmp_dst, e_cidx);
            check(int'(cmp_tag) == m_mtag[e_cidx], "R8", "cmp_tag", cmp_tag, m_mtag[e_cidx]);
         end
         acc = cur_v && e_rdy;
         @(posedge clk);
         model_step(acc);
         if (acc) cur_v = 0;
      end
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL R4 watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end
endmodule